// File: doc/BRIEF.md
# Parallel-Port Address Latch Sequencer

This block sits on the device side of a bridge between a PC parallel port and a disk-style register file. The host drives an 8-bit data bus and a 4-bit control bus. To select a register, the host puts an address/command byte on the data lines. It then steps the control lines through a fixed handshake. The block brings both buses into its own clock domain through two-stage synchronizers and follows the handshake with a small state machine. When the handshake ends, it decodes the captured byte into a register index, a register-space select and a transfer mode for the downstream read and write engines. It reports a good capture with a one-cycle `addr_valid` pulse.

The handshake starts from the idle code 0x4 and runs 0xC, 0xE, 0xE, 0xC, 0x4, 0x4, 0x4. The block samples the lines synchronously, so a code that is held for several steps looks the same as one held for one step. The block therefore follows changes of level: idle, then 0xC, then 0xE, then 0xC, then back to 0x4. If the lines leave this order before it ends, the capture is dropped. The state machine then waits for the next 0xC, and that 0xC starts a new capture. The byte 0x20 is a disconnect command. It gives a one-cycle `disconnect` pulse and returns the decoded fields to zero.

Top module: `ppa_latch_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, `addr_valid` and `disconnect` go to 0 and `reg_index`, `space_sel` and `mode` go to 0.
- R2: The control level sequence 0x4, 0xC, 0xE, 0xC, 0x4 completes a capture, and any repeat of a level counts as one step. `addr_valid` is high for exactly the cycle after the third rising clock edge that samples the final 0x4.
- R3: For a captured byte b, `reg_index` = b[2:0]. `space_sel` is 0 when b[3] is set (0x08, task register file) and 1 when b[4] is set (0x10, command/control set).
- R4: `mode` comes from b[7:6]. 00 gives 0 (single register access). 10 gives 1 (wide enhanced-port block read, 0x80 prefix). 11 gives 2 (byte-wide block transfer, 0xC0 prefix, which includes the block-write byte 0xC8).
- R5: A captured byte 0x20 gives a one-cycle `disconnect` pulse at the same latency as R2. `addr_valid` stays low, and `reg_index`, `space_sel` and `mode` become 0.
- R6: A captured byte that is not 0x20 and does not have exactly one of b[3] or b[4] set, or has b[5] set, or has b[7:6] = 01, gives no pulse and leaves the decoded fields unchanged.
- R7: If the control lines leave the R2 order before it ends, the capture is dropped. No pulse follows and the fields are unchanged.
- R8: After a dropped capture, the next 0xC re-arms capture with no return to 0x4 first.
- R9: The byte is taken from the data lines when 0xC first appears. Later changes on the data lines do not affect that capture.
- R10: The decoded fields keep their value between pulses, whatever other control codes the host drives.
- R11: `addr_valid` and `disconnect` never stay high for two cycles in a row, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_data | input | 8 | Host data lines (asynchronous) |
| host_ctrl | input | 4 | Host control lines (asynchronous) |
| addr_valid | output | 1 | One-cycle pulse when a valid address byte has been captured |
| reg_index | output | 3 | Register index of the last valid capture |
| space_sel | output | 1 | 0 = task register file, 1 = command/control set |
| mode | output | 3 | Transfer mode of the last valid capture |
| disconnect | output | 1 | One-cycle pulse for the disconnect command |

## Verification
Every result arrives three rising edges after the final 0x4 reaches the pins. Two edges go to the synchronizer and one to the output register. The latency test drives that 0x4 on a falling edge and samples 1 ns after each of the next three rising edges. It expects the pulse only after the third and expects it gone one edge later. The other scenarios count pulses 1 ns after each rising edge. They read the fields several cycles after the handshake ends, when all pipelining has finished. For the no-effect cases, the bench checks that neither pulse count moved and that the fields still show the previous capture.

// File: rtl/ppa_pkg.sv
// Package: shared widths, handshake codes, mode encoding and detector states
// for the parallel-port address latch sequencer.
package ppa_pkg;
    localparam int DATA_W = 8;
    localparam int CTRL_W = 4;
    localparam int IDX_W  = 3;
    localparam int MODE_W = 3;

    localparam logic [CTRL_W-1:0] CODE_IDLE = 4'h4;
    localparam logic [CTRL_W-1:0] CODE_SEL  = 4'hC;
    localparam logic [CTRL_W-1:0] CODE_CLK  = 4'hE;

    localparam logic [DATA_W-1:0] BYTE_DISC = 8'h20;

    typedef enum logic [MODE_W-1:0] {
        MODE_REG      = 3'd0,
        MODE_WIDE_RD  = 3'd1,
        MODE_BYTE_BLK = 3'd2
    } xfer_mode_e;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_SEL1 = 2'd1,
        ST_CLK  = 2'd2,
        ST_SEL2 = 2'd3
    } det_state_e;
endpackage

// File: rtl/ppa_sync.sv
// Module: multi-stage synchronizer for a bus of asynchronous host lines.
// Assumes each line is quasi-static around the handshake, so skew between
// bits is resolved by the handshake itself, not by this module.
module ppa_sync #(
    parameter int              W       = 8,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    // Shift the asynchronous value through the register chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ppa_seq_det.sv
// Module: handshake detector. Follows level changes of the synchronized
// control code through idle -> SEL -> CLK -> SEL -> idle. It takes the data
// byte when SEL first appears and strobes cap_stb in the cycle the final
// idle code is seen. Any other code aborts, and the next SEL re-arms.
// Assumes the inputs are already in the clk domain.
module ppa_seq_det
    import ppa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_s,
    input  logic [DATA_W-1:0] data_s,
    output logic              cap_stb,
    output logic [DATA_W-1:0] cap_byte
);
    det_state_e state_q;

    // Step the handshake state machine and take the byte on SEL entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_HUNT;
            cap_byte <= '0;
        end else begin
            unique case (state_q)
                ST_HUNT: if (ctrl_s == CODE_SEL) begin
                    state_q  <= ST_SEL1;
                    cap_byte <= data_s;
                end
                ST_SEL1: if (ctrl_s == CODE_CLK)       state_q <= ST_CLK;
                         else if (ctrl_s != CODE_SEL)  state_q <= ST_HUNT;
                ST_CLK:  if (ctrl_s == CODE_SEL)       state_q <= ST_SEL2;
                         else if (ctrl_s != CODE_CLK)  state_q <= ST_HUNT;
                ST_SEL2: if (ctrl_s != CODE_SEL)       state_q <= ST_HUNT;
                default:                               state_q <= ST_HUNT;
            endcase
        end
    end

    // The capture ends when the return to idle follows the second SEL.
    assign cap_stb = (state_q == ST_SEL2) && (ctrl_s == CODE_IDLE);
endmodule

// File: rtl/ppa_decode.sv
// Module: combinational decode of a captured address/command byte into a
// disconnect flag, a validity flag, register index, space and mode.
// Assumes the byte is stable while the strobe that uses it is high.
module ppa_decode
    import ppa_pkg::*;
(
    input  logic [DATA_W-1:0] byte_in,
    output logic              is_disc,
    output logic              is_valid,
    output logic [IDX_W-1:0]  idx,
    output logic              space,
    output logic [MODE_W-1:0] mode_out
);
    // Classify the byte and pull out its fields.
    always_comb begin
        is_disc  = (byte_in == BYTE_DISC);
        is_valid = !is_disc && !byte_in[5] && (byte_in[3] ^ byte_in[4])
                   && (byte_in[7:6] != 2'b01);
        idx      = byte_in[IDX_W-1:0];
        space    = byte_in[4];
        unique case (byte_in[7:6])
            2'b10:   mode_out = MODE_WIDE_RD;
            2'b11:   mode_out = MODE_BYTE_BLK;
            default: mode_out = MODE_REG;
        endcase
    end
endmodule

// File: rtl/ppa_latch_seq.sv
// Module: top of the address latch sequencer. Synchronizes the host buses,
// detects the handshake, decodes the byte and registers all outputs.
// Assumes host_data is set before the handshake and held through SEL entry.
module ppa_latch_seq
    import ppa_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] host_data,
    input  logic [CTRL_W-1:0] host_ctrl,
    output logic              addr_valid,
    output logic [IDX_W-1:0]  reg_index,
    output logic              space_sel,
    output logic [MODE_W-1:0] mode,
    output logic              disconnect
);
    logic [DATA_W-1:0] data_s;
    logic [CTRL_W-1:0] ctrl_s;
    logic              cap_stb;
    logic [DATA_W-1:0] cap_byte;
    logic              dec_disc, dec_valid, dec_space;
    logic [IDX_W-1:0]  dec_idx;
    logic [MODE_W-1:0] dec_mode;

    ppa_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_data (
        .clk(clk), .rst_n(rst_n), .d(host_data), .q(data_s)
    );

    ppa_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(CODE_IDLE)) u_sync_ctrl (
        .clk(clk), .rst_n(rst_n), .d(host_ctrl), .q(ctrl_s)
    );

    ppa_seq_det u_det (
        .clk(clk), .rst_n(rst_n), .ctrl_s(ctrl_s), .data_s(data_s),
        .cap_stb(cap_stb), .cap_byte(cap_byte)
    );

    ppa_decode u_dec (
        .byte_in(cap_byte), .is_disc(dec_disc), .is_valid(dec_valid),
        .idx(dec_idx), .space(dec_space), .mode_out(dec_mode)
    );

    // Register pulses and decoded fields on a completed capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_valid <= 1'b0;
            disconnect <= 1'b0;
            reg_index  <= '0;
            space_sel  <= 1'b0;
            mode       <= '0;
        end else begin
            addr_valid <= cap_stb && dec_valid;
            disconnect <= cap_stb && dec_disc;
            if (cap_stb && dec_disc) begin
                reg_index <= '0;
                space_sel <= 1'b0;
                mode      <= '0;
            end else if (cap_stb && dec_valid) begin
                reg_index <= dec_idx;
                space_sel <= dec_space;
                mode      <= dec_mode;
            end
        end
    end
endmodule

// File: rtl/ppa_latch_seq_chk.sv
// Module: assertion checker for ppa_latch_seq, attached by bind.
// Watches only the top-level ports.
module ppa_latch_seq_chk
    import ppa_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] host_data,
    input logic [CTRL_W-1:0] host_ctrl,
    input logic              addr_valid,
    input logic [IDX_W-1:0]  reg_index,
    input logic              space_sel,
    input logic [MODE_W-1:0] mode,
    input logic              disconnect
);
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> !addr_valid); // R11
    AST_DISC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        disconnect |=> !disconnect); // R11
    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_valid && disconnect)); // R11
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> (mode <= 3'd2)); // R4
    AST_DISC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        disconnect |-> (reg_index == '0 && mode == '0 && !space_sel)); // R5
    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(reg_index) && $stable(space_sel) && $stable(mode))
        |-> (addr_valid || disconnect)); // R10
endmodule

bind ppa_latch_seq ppa_latch_seq_chk u_chk (.*);

// File: tb/ppa_latch_seq_tb.sv
`timescale 1ns/1ps
// Directed bench for ppa_latch_seq: one task per scenario.
module ppa_latch_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] host_data = 8'h00;
    logic [3:0] host_ctrl = 4'h4;
    logic       addr_valid, space_sel, disconnect;
    logic [2:0] reg_index, mode;

    int n_checks = 0;
    int n_fail   = 0;
    int n_valid  = 0;
    int n_disc   = 0;

    always #2.5 clk = ~clk;

    ppa_latch_seq u_dut (
        .clk(clk), .rst_n(rst_n), .host_data(host_data), .host_ctrl(host_ctrl),
        .addr_valid(addr_valid), .reg_index(reg_index), .space_sel(space_sel),
        .mode(mode), .disconnect(disconnect)
    );

    // Count output pulses 1 ns after each rising edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && addr_valid) n_valid++;
        if (rst_n && disconnect) n_disc++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] code);
        host_ctrl = code;
        @(negedge clk);
    endtask

    // Full handshake for byte b, then let the pipeline drain.
    task automatic send(input logic [7:0] b);
        host_data = b;
        step(4'h4); step(4'h4);
        step(4'hC); step(4'hE); step(4'hE); step(4'hC);
        step(4'h4); step(4'h4); step(4'h4);
        repeat (3) @(negedge clk);
    endtask

    task automatic chk_fields(input string tag, input int idx, input int sp, input int md);
        chk({tag, " reg_index"}, reg_index, idx);
        chk({tag, " space_sel"}, space_sel, sp);
        chk({tag, " mode"}, mode, md);
    endtask

    task automatic t_reset();
        chk("R1 addr_valid", addr_valid, 0);
        chk("R1 disconnect", disconnect, 0);
        chk_fields("R1", 0, 0, 0);
    endtask

    task automatic t_latency();
        int v0 = n_valid;
        host_data = 8'h0B;
        step(4'h4); step(4'h4);
        step(4'hC); step(4'hE); step(4'hE); step(4'hC);
        host_ctrl = 4'h4;
        repeat (2) @(posedge clk);
        #1 chk("R2 not early", addr_valid, 0);
        @(posedge clk);
        #1 chk("R2 pulse due", addr_valid, 1);
        @(posedge clk);
        #1 chk("R2 pulse gone", addr_valid, 0);
        @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R2 one pulse", n_valid - v0, 1);
        chk_fields("R3 0x0B", 3, 0, 0);
    endtask

    task automatic t_decode(input logic [7:0] b, input int idx, input int sp, input int md);
        int v0 = n_valid;
        send(b);
        chk("R2 capture pulse", n_valid - v0, 1);
        chk_fields($sformatf("R3/R4 byte %0h", b), idx, sp, md);
    endtask

    task automatic t_disconnect();
        int v0 = n_valid, d0 = n_disc;
        send(8'h20);
        chk("R5 disc pulse", n_disc - d0, 1);
        chk("R5 no addr_valid", n_valid - v0, 0);
        chk_fields("R5 cleared", 0, 0, 0);
    endtask

    task automatic t_invalid(input logic [7:0] b);
        int v0 = n_valid, d0 = n_disc;
        send(b);
        chk($sformatf("R6 no pulse %0h", b), (n_valid - v0) + (n_disc - d0), 0);
        chk_fields($sformatf("R6 unchanged %0h", b), 5, 1, 1);
    endtask

    task automatic t_abort();
        int v0 = n_valid;
        host_data = 8'h0A;
        step(4'h4); step(4'hC); step(4'hE); step(4'h6); step(4'hC); step(4'h4);
        step(4'h4); repeat (4) @(negedge clk);
        chk("R7 no pulse", n_valid - v0, 0);
        chk_fields("R7 unchanged", 5, 1, 1);
    endtask

    task automatic t_rearm();
        int v0 = n_valid;
        host_data = 8'h0E;
        step(4'h4); step(4'hC); step(4'hE); step(4'h7);
        step(4'hC); step(4'hE); step(4'hC); step(4'h4);
        repeat (4) @(negedge clk);
        chk("R8 rearm pulse", n_valid - v0, 1);
        chk_fields("R8 rearm", 6, 0, 0);
    endtask

    task automatic t_data_late();
        host_data = 8'h12;
        step(4'h4); step(4'h4); step(4'hC);
        host_data = 8'h0F;
        step(4'hE); step(4'hC); step(4'h4);
        repeat (4) @(negedge clk);
        chk_fields("R9 early byte", 2, 1, 0);
    endtask

    task automatic t_hold();
        int v0 = n_valid;
        host_data = 8'h55;
        step(4'h6); step(4'h4); step(4'h5); step(4'h7); step(4'h5); step(4'h4);
        step(4'hE); step(4'h4);
        repeat (4) @(negedge clk);
        chk("R10 no pulse", n_valid - v0, 0);
        chk_fields("R10 hold", 2, 1, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_latency();
        t_decode(8'h0C, 4, 0, 0);
        t_decode(8'h17, 7, 1, 0);
        t_decode(8'h89, 1, 0, 1);
        t_decode(8'h96, 6, 1, 1);
        t_decode(8'hC8, 0, 0, 2);
        t_decode(8'hD3, 3, 1, 2);
        t_disconnect();
        t_decode(8'h95, 5, 1, 1);
        t_invalid(8'h18);
        t_invalid(8'h05);
        t_invalid(8'h48);
        t_invalid(8'h28);
        t_abort();
        t_rearm();
        t_data_late();
        t_hold();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule